// File: doc/BRIEF.md
# Adaptive Page Close Decider

After a memory controller issues a column command, this block decides whether the row that was just accessed should be closed by an auto-precharge or left open for later accesses. It is given the issued access: its rank, bank, row and direction, and the slot it occupies in its own queues. It also receives the page policy mode, the number of column accesses the row has served, and the command and data-ready times. With these it scans the pending entries of every priority queue of the same direction, one slot per cycle. It looks for further accesses to the same row and for accesses that would need a different row in the same bank.

The scan ends at the first pending same-row access, or after the last slot. The block then gives a one-cycle done pulse, a close flag and a new earliest-precharge time for the bank. That time is never earlier than the time supplied with the request. The controller keeps the queue contents stable while the block reports busy. A new request can be started in the cycle that carries the done pulse.

Top module: `page_close_decider`

## Requirements
- R1: During and after reset, `done_o`, `busy_o` and `close_o` are 0 and `pre_at_o` is 0.
- R2: A request is accepted on a clock edge where `start_i` is 1 and `busy_o` is 0. From the next cycle `busy_o` is 1 until the done pulse. While busy, `start_i` and every request input are ignored.
- R3: Only the queues of the issued direction are scanned: `is_read_i`=1 selects the `rd_*` slots and 0 selects the `wr_*` slots. Entries in the other direction's slots have no effect on the result.
- R4: The slot whose flat index equals `self_slot_i` is never counted as a hit or a conflict.
- R5: A valid slot with equal rank, bank and row is a further hit. Slots are scanned in flat index order, where flat index = priority×DEPTH + position. If the first hit is at index k, `done_o` rises k+1 clock edges after the accepting edge. If there is no hit, it rises after SLOTS edges.
- R6: A valid slot with equal rank and bank but a different row is a bank conflict. A slot of another rank is never a conflict.
- R7: `mode_i` encoding: 0 open, 1 open-adaptive, 2 close, 3 close-adaptive. Open-adaptive closes only when no hit was found and a conflict was seen. Close-adaptive closes whenever no hit was found.
- R8: Close mode always closes. Open mode closes only on the access limit of R9.
- R9: When MAX_ROW_ACC is nonzero and `row_acc_i` ≥ MAX_ROW_ACC, the row closes in every mode.
- R10: `pre_at_o` = max(`pre_prev_i`, `cmd_time_i`+T_RTP) for reads, and max(`pre_prev_i`, `ready_time_i`+T_WR) for writes.
- R11: `done_o` is high for exactly one cycle per accepted request. `close_o` and `pre_at_o` change only with a done pulse and hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe |
| is_read_i | input | 1 | Issued access direction, 1 = read |
| rank_i | input | RANK_W | Issued rank |
| bank_i | input | BANK_W | Issued bank |
| row_i | input | ROW_W | Issued row |
| self_slot_i | input | SLOT_W | Flat slot index of the issued entry |
| mode_i | input | 2 | Page policy mode |
| row_acc_i | input | ACC_W | Column accesses served by the row, this one included |
| cmd_time_i | input | TW | Column command time |
| ready_time_i | input | TW | Data ready time |
| pre_prev_i | input | TW | Bank's earliest-precharge time before this access |
| rd_valid_i | input | SLOTS | Read slot valid flags |
| rd_rank_i | input | SLOTS*RANK_W | Read slot ranks, slot g at bits g*RANK_W |
| rd_bank_i | input | SLOTS*BANK_W | Read slot banks |
| rd_row_i | input | SLOTS*ROW_W | Read slot rows |
| wr_valid_i | input | SLOTS | Write slot valid flags |
| wr_rank_i | input | SLOTS*RANK_W | Write slot ranks |
| wr_bank_i | input | SLOTS*BANK_W | Write slot banks |
| wr_row_i | input | SLOTS*ROW_W | Write slot rows |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle result strobe |
| close_o | output | 1 | Close the row with auto-precharge |
| pre_at_o | output | TW | Updated earliest-precharge time |

## Verification
The assertions check on every cycle that the done strobe lasts a single cycle and that an idle start makes the block busy. They also check that the reported precharge time is never earlier than the supplied one, that close mode and the access limit always close, and that plain open mode without the limit keeps the row open. Which direction is scanned, exclusion of the issued slot, the hit and conflict tests, the early stop and its exact latency, and the adaptive outcomes depend on queue contents. Only the bench's scenarios show these, compared cycle by cycle against a behavioural model.

// File: rtl/page_close_pkg.sv
package page_close_pkg;

    typedef enum logic [1:0] {
        PG_OPEN        = 2'd0,
        PG_OPEN_ADAPT  = 2'd1,
        PG_CLOSE       = 2'd2,
        PG_CLOSE_ADAPT = 2'd3
    } page_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

endpackage

// File: rtl/pcd_slot_cmp.sv
module pcd_slot_cmp #(
    parameter int RANK_W = 1,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14
) (
    input  logic              use_rd_i,
    input  logic              is_self_i,
    input  logic [RANK_W-1:0] key_rank_i,
    input  logic [BANK_W-1:0] key_bank_i,
    input  logic [ROW_W-1:0]  key_row_i,
    input  logic              rd_valid_i,
    input  logic [RANK_W-1:0] rd_rank_i,
    input  logic [BANK_W-1:0] rd_bank_i,
    input  logic [ROW_W-1:0]  rd_row_i,
    input  logic              wr_valid_i,
    input  logic [RANK_W-1:0] wr_rank_i,
    input  logic [BANK_W-1:0] wr_bank_i,
    input  logic [ROW_W-1:0]  wr_row_i,
    output logic              hit_o,
    output logic              conflict_o
);
    logic              valid_sel;
    logic [RANK_W-1:0] rank_sel;
    logic [BANK_W-1:0] bank_sel;
    logic [ROW_W-1:0]  row_sel;
    logic              same_bank;

    always_comb begin
        valid_sel  = use_rd_i ? rd_valid_i : wr_valid_i;
        rank_sel   = use_rd_i ? rd_rank_i  : wr_rank_i;
        bank_sel   = use_rd_i ? rd_bank_i  : wr_bank_i;
        row_sel    = use_rd_i ? rd_row_i   : wr_row_i;
        same_bank  = valid_sel && !is_self_i &&
                     (rank_sel == key_rank_i) && (bank_sel == key_bank_i);
        hit_o      = same_bank && (row_sel == key_row_i);
        conflict_o = same_bank && (row_sel != key_row_i);
    end
endmodule

// File: rtl/pcd_close_policy.sv
module pcd_close_policy
    import page_close_pkg::*;
#(
    parameter int ACC_W       = 8,
    parameter int MAX_ROW_ACC = 8
) (
    input  page_mode_e       mode_i,
    input  logic [ACC_W-1:0] row_acc_i,
    input  logic             hit_i,
    input  logic             conflict_i,
    output logic             close_o
);
    logic at_limit;

    always_comb begin
        at_limit = (MAX_ROW_ACC != 0) && (row_acc_i >= ACC_W'(MAX_ROW_ACC));
        unique case (mode_i)
            PG_OPEN:        close_o = at_limit;
            PG_OPEN_ADAPT:  close_o = at_limit || (!hit_i && conflict_i);
            PG_CLOSE:       close_o = 1'b1;
            PG_CLOSE_ADAPT: close_o = at_limit || !hit_i;
            default:        close_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/pcd_pre_time.sv
module pcd_pre_time #(
    parameter int TW    = 32,
    parameter int T_RTP = 4,
    parameter int T_WR  = 12
) (
    input  logic          is_read_i,
    input  logic [TW-1:0] cmd_time_i,
    input  logic [TW-1:0] ready_time_i,
    input  logic [TW-1:0] prev_i,
    output logic [TW-1:0] pre_at_o
);
    logic [TW-1:0] cand;

    always_comb begin
        cand     = is_read_i ? (cmd_time_i + TW'(T_RTP)) : (ready_time_i + TW'(T_WR));
        pre_at_o = (cand > prev_i) ? cand : prev_i;
    end
endmodule

// File: rtl/page_close_decider.sv
module page_close_decider
    import page_close_pkg::*;
#(
    parameter int N_RANKS     = 2,
    parameter int N_BANKS     = 8,
    parameter int ROW_W       = 14,
    parameter int N_PRIO      = 4,
    parameter int DEPTH       = 4,
    parameter int ACC_W       = 8,
    parameter int MAX_ROW_ACC = 8,
    parameter int TW          = 32,
    parameter int T_RTP       = 4,
    parameter int T_WR        = 12,
    localparam int RANK_W     = (N_RANKS > 1) ? $clog2(N_RANKS) : 1,
    localparam int BANK_W     = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
    localparam int SLOTS      = N_PRIO * DEPTH,
    localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      is_read_i,
    input  logic [RANK_W-1:0]         rank_i,
    input  logic [BANK_W-1:0]         bank_i,
    input  logic [ROW_W-1:0]          row_i,
    input  logic [SLOT_W-1:0]         self_slot_i,
    input  logic [1:0]                mode_i,
    input  logic [ACC_W-1:0]          row_acc_i,
    input  logic [TW-1:0]             cmd_time_i,
    input  logic [TW-1:0]             ready_time_i,
    input  logic [TW-1:0]             pre_prev_i,
    input  logic [SLOTS-1:0]          rd_valid_i,
    input  logic [SLOTS*RANK_W-1:0]   rd_rank_i,
    input  logic [SLOTS*BANK_W-1:0]   rd_bank_i,
    input  logic [SLOTS*ROW_W-1:0]    rd_row_i,
    input  logic [SLOTS-1:0]          wr_valid_i,
    input  logic [SLOTS*RANK_W-1:0]   wr_rank_i,
    input  logic [SLOTS*BANK_W-1:0]   wr_bank_i,
    input  logic [SLOTS*ROW_W-1:0]    wr_row_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      close_o,
    output logic [TW-1:0]             pre_at_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        scan_state_e       st;
        logic [SLOT_W-1:0] idx;
        logic              is_read;
        logic [RANK_W-1:0] rank;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [SLOT_W-1:0] self_slot;
        page_mode_e        mode;
        logic [ACC_W-1:0]  acc;
        logic [TW-1:0]     cmd;
        logic [TW-1:0]     ready;
        logic [TW-1:0]     prev;
        logic              conf_seen;
        logic              done;
        logic              close;
        logic [TW-1:0]     pre;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [SLOTS-1:0] hit_vec;
    logic [SLOTS-1:0] conf_vec;
    logic             cur_hit;
    logic             cur_conf;
    logic             close_w;
    logic [TW-1:0]    pre_w;

    // one comparator per slot, direction chosen by the latched request
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        pcd_slot_cmp #(
            .RANK_W (RANK_W),
            .BANK_W (BANK_W),
            .ROW_W  (ROW_W)
        ) u_cmp (
            .use_rd_i   (ctx_q.is_read),
            .is_self_i  (ctx_q.self_slot == SLOT_W'(g)),
            .key_rank_i (ctx_q.rank),
            .key_bank_i (ctx_q.bank),
            .key_row_i  (ctx_q.row),
            .rd_valid_i (rd_valid_i[g]),
            .rd_rank_i  (rd_rank_i[g*RANK_W +: RANK_W]),
            .rd_bank_i  (rd_bank_i[g*BANK_W +: BANK_W]),
            .rd_row_i   (rd_row_i[g*ROW_W +: ROW_W]),
            .wr_valid_i (wr_valid_i[g]),
            .wr_rank_i  (wr_rank_i[g*RANK_W +: RANK_W]),
            .wr_bank_i  (wr_bank_i[g*BANK_W +: BANK_W]),
            .wr_row_i   (wr_row_i[g*ROW_W +: ROW_W]),
            .hit_o      (hit_vec[g]),
            .conflict_o (conf_vec[g])
        );
    end

    assign cur_hit  = hit_vec[ctx_q.idx];
    assign cur_conf = conf_vec[ctx_q.idx];

    pcd_close_policy #(
        .ACC_W       (ACC_W),
        .MAX_ROW_ACC (MAX_ROW_ACC)
    ) u_policy (
        .mode_i     (ctx_q.mode),
        .row_acc_i  (ctx_q.acc),
        .hit_i      (cur_hit),
        .conflict_i (ctx_q.conf_seen || cur_conf),
        .close_o    (close_w)
    );

    pcd_pre_time #(
        .TW    (TW),
        .T_RTP (T_RTP),
        .T_WR  (T_WR)
    ) u_pre (
        .is_read_i    (ctx_q.is_read),
        .cmd_time_i   (ctx_q.cmd),
        .ready_time_i (ctx_q.ready),
        .prev_i       (ctx_q.prev),
        .pre_at_o     (pre_w)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctx_d.st        = ST_SCAN;
                    ctx_d.idx       = '0;
                    ctx_d.is_read   = is_read_i;
                    ctx_d.rank      = rank_i;
                    ctx_d.bank      = bank_i;
                    ctx_d.row       = row_i;
                    ctx_d.self_slot = self_slot_i;
                    ctx_d.mode      = page_mode_e'(mode_i);
                    ctx_d.acc       = row_acc_i;
                    ctx_d.cmd       = cmd_time_i;
                    ctx_d.ready     = ready_time_i;
                    ctx_d.prev      = pre_prev_i;
                    ctx_d.conf_seen = 1'b0;
                end
            end
            ST_SCAN: begin
                if (cur_hit || (ctx_q.idx == LAST_SLOT)) begin
                    ctx_d.st    = ST_IDLE;
                    ctx_d.done  = 1'b1;
                    ctx_d.close = close_w;
                    ctx_d.pre   = pre_w;
                end else begin
                    ctx_d.idx       = ctx_q.idx + SLOT_W'(1);
                    ctx_d.conf_seen = ctx_q.conf_seen || cur_conf;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy_o   = (ctx_q.st == ST_SCAN);
    assign done_o   = ctx_q.done;
    assign close_o  = ctx_q.close;
    assign pre_at_o = ctx_q.pre;

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R10
    pre_not_earlier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pre_at_o >= ctx_q.prev));

    // R8
    close_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ctx_q.mode == PG_CLOSE) |-> close_o);

    // R8
    open_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ctx_q.mode == PG_OPEN &&
         ((MAX_ROW_ACC == 0) || (ctx_q.acc < ACC_W'(MAX_ROW_ACC)))) |-> !close_o);

    // R9
    acc_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (MAX_ROW_ACC != 0) && (ctx_q.acc >= ACC_W'(MAX_ROW_ACC))) |-> close_o);

endmodule

// File: tb/sim_page_close_decider.sv
`timescale 1ns/1ps
module sim_page_close_decider;
    localparam int RANK_W = 1;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 14;
    localparam int SLOTS  = 16;
    localparam int SLOT_W = 4;
    localparam int ACC_W  = 8;
    localparam int TW     = 32;
    localparam int MAXACC = 8;
    localparam int TRTP   = 4;
    localparam int TWR    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic is_read = 1'b1;
    logic [RANK_W-1:0] rank = '0;
    logic [BANK_W-1:0] bank = '0;
    logic [ROW_W-1:0] row = '0;
    logic [SLOT_W-1:0] self_slot = '0;
    logic [1:0] mode = 2'd0;
    logic [ACC_W-1:0] acc = '0;
    logic [TW-1:0] cmd_t = '0, ready_t = '0, prev_t = '0;
    logic [SLOTS-1:0] rd_v = '0, wr_v = '0;
    logic [SLOTS*RANK_W-1:0] rd_rk = '0, wr_rk = '0;
    logic [SLOTS*BANK_W-1:0] rd_bk = '0, wr_bk = '0;
    logic [SLOTS*ROW_W-1:0] rd_rw = '0, wr_rw = '0;
    logic busy, done, close_f;
    logic [TW-1:0] pre_at;

    page_close_decider u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .is_read_i(is_read),
        .rank_i(rank), .bank_i(bank), .row_i(row), .self_slot_i(self_slot),
        .mode_i(mode), .row_acc_i(acc), .cmd_time_i(cmd_t),
        .ready_time_i(ready_t), .pre_prev_i(prev_t),
        .rd_valid_i(rd_v), .rd_rank_i(rd_rk), .rd_bank_i(rd_bk), .rd_row_i(rd_rw),
        .wr_valid_i(wr_v), .wr_rank_i(wr_rk), .wr_bank_i(wr_bk), .wr_row_i(wr_rw),
        .busy_o(busy), .done_o(done), .close_o(close_f), .pre_at_o(pre_at)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    int cycles = 0;

    // behavioural reference model
    bit m_busy = 0, m_done = 0, m_close = 0;
    longint m_pre = 0;
    int m_left = 0;
    bit p_close;
    longint p_pre;
    int p_lat;

    task automatic eval_request();
        bit hit = 0, conf = 0, lim;
        int k = 0;
        longint cand;
        for (int s = 0; s < SLOTS; s++) begin
            bit v;
            int rk, bk, rw;
            if (s == int'(self_slot)) continue;
            v  = is_read ? rd_v[s] : wr_v[s];
            rk = is_read ? int'(rd_rk[s*RANK_W +: RANK_W]) : int'(wr_rk[s*RANK_W +: RANK_W]);
            bk = is_read ? int'(rd_bk[s*BANK_W +: BANK_W]) : int'(wr_bk[s*BANK_W +: BANK_W]);
            rw = is_read ? int'(rd_rw[s*ROW_W +: ROW_W]) : int'(wr_rw[s*ROW_W +: ROW_W]);
            if (v && rk == int'(rank) && bk == int'(bank)) begin
                if (rw == int'(row)) begin hit = 1; k = s; break; end
                else conf = 1;
            end
        end
        p_lat = hit ? k + 1 : SLOTS;
        lim = (MAXACC != 0) && (int'(acc) >= MAXACC);
        case (mode)
            2'd0: p_close = lim;
            2'd1: p_close = lim || (!hit && conf);
            2'd2: p_close = 1'b1;
            default: p_close = lim || !hit;
        endcase
        cand = is_read ? longint'(cmd_t) + TRTP : longint'(ready_t) + TWR;
        p_pre = (cand > longint'(prev_t)) ? cand : longint'(prev_t);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_close = 0; m_pre = 0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_close = p_close; m_pre = p_pre;
                end
            end else if (start) begin
                eval_request();
                m_busy = 1;
                m_left = p_lat;
            end
        end
    end

    task automatic cmp(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cmp("busy", longint'(busy), longint'(m_busy));
        cmp("done", longint'(done), longint'(m_done));
        cmp("close", longint'(close_f), longint'(m_close));
        cmp("pre_at", longint'(pre_at), m_pre);
    end

    bit wd_fired = 0;
    always @(posedge clk) begin
        if (cycles > 20000 && !wd_fired) begin
            wd_fired = 1;
            failures++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic clear_q();
        rd_v = '0; wr_v = '0; rd_rk = '0; wr_rk = '0;
        rd_bk = '0; wr_bk = '0; rd_rw = '0; wr_rw = '0;
    endtask

    task automatic put(bit wr, int s, int rk, int bk, int rw);
        if (wr) begin
            wr_v[s] = 1'b1; wr_rk[s*RANK_W +: RANK_W] = RANK_W'(rk);
            wr_bk[s*BANK_W +: BANK_W] = BANK_W'(bk); wr_rw[s*ROW_W +: ROW_W] = ROW_W'(rw);
        end else begin
            rd_v[s] = 1'b1; rd_rk[s*RANK_W +: RANK_W] = RANK_W'(rk);
            rd_bk[s*BANK_W +: BANK_W] = BANK_W'(bk); rd_rw[s*ROW_W +: ROW_W] = ROW_W'(rw);
        end
    endtask

    task automatic issue(string req, bit rd, int rk, int bk, int rw, int self_s,
                         int md, int ac, int c, int r, int p, bit exp_close);
        cur_req = req;
        is_read = rd; rank = RANK_W'(rk); bank = BANK_W'(bk); row = ROW_W'(rw);
        self_slot = SLOT_W'(self_s); mode = md[1:0]; acc = ACC_W'(ac);
        cmd_t = TW'(c); ready_t = TW'(r); prev_t = TW'(p);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        cmp("close_expected", longint'(close_f), longint'(exp_close));
        @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: hit at slot 5, open-adaptive keeps row open, latency 6
        clear_q();
        put(0, 2, 0, 3, 99);
        put(0, 5, 0, 3, 40);
        issue("R5", 1, 0, 3, 40, 0, 1, 1, 100, 110, 0, 0);
        // R5: hit at slot 0, shortest scan
        clear_q();
        put(0, 0, 1, 6, 7);
        issue("R5", 1, 1, 6, 7, 9, 3, 1, 10, 20, 0, 0);
        // R5: hit in priority 2 (slot 9), later conflict unseen
        clear_q();
        put(0, 9, 1, 2, 300);
        put(0, 12, 1, 2, 301);
        issue("R5", 1, 1, 2, 300, 0, 1, 1, 10, 20, 0, 0);

        // R4: only match is the issued slot itself, plus a conflict
        clear_q();
        put(0, 4, 0, 1, 50);
        put(0, 11, 0, 1, 51);
        issue("R4", 1, 0, 1, 50, 4, 1, 1, 10, 20, 0, 1);

        // R3: write-side hit ignored for a read, read-side conflict closes
        clear_q();
        put(1, 1, 0, 2, 77);
        put(0, 3, 0, 2, 78);
        issue("R3", 1, 0, 2, 77, 15, 1, 1, 10, 20, 0, 1);
        // R3: same contents, write issued: write hit keeps open
        issue("R3", 0, 0, 2, 77, 15, 1, 1, 10, 20, 0, 0);

        // R6: other rank same bank is no conflict
        clear_q();
        put(0, 6, 1, 4, 9);
        issue("R6", 1, 0, 4, 8, 0, 1, 1, 10, 20, 0, 0);
        // R6: same rank and bank, other row is a conflict
        put(0, 7, 0, 4, 9);
        issue("R6", 1, 0, 4, 8, 0, 1, 1, 10, 20, 0, 1);

        // R7: close-adaptive with empty queue closes; with hit stays open
        clear_q();
        issue("R7", 1, 0, 0, 1, 0, 3, 1, 10, 20, 0, 1);
        put(0, 8, 0, 0, 1);
        issue("R7", 1, 0, 0, 1, 0, 3, 1, 10, 20, 0, 0);
        // R7: open-adaptive, no hit, no conflict stays open
        clear_q();
        issue("R7", 1, 0, 0, 1, 0, 1, 1, 10, 20, 0, 0);

        // R8: close mode with a hit still closes; open with conflict stays open
        clear_q();
        put(0, 2, 0, 5, 10);
        issue("R8", 1, 0, 5, 10, 0, 2, 1, 10, 20, 0, 1);
        clear_q();
        put(0, 2, 0, 5, 11);
        issue("R8", 1, 0, 5, 10, 0, 0, 1, 10, 20, 0, 0);

        // R9: access limit closes open mode with a hit; one below does not
        clear_q();
        put(0, 3, 0, 5, 10);
        issue("R9", 1, 0, 5, 10, 0, 0, 8, 10, 20, 0, 1);
        issue("R9", 1, 0, 5, 10, 0, 1, 7, 10, 20, 0, 0);

        // R10: precharge time for reads and writes
        clear_q();
        issue("R10", 1, 0, 0, 0, 0, 0, 1, 100, 150, 50, 0);
        cmp("pre_read", longint'(pre_at), 104);
        issue("R10", 1, 0, 0, 0, 0, 0, 1, 100, 150, 200, 0);
        cmp("pre_prev", longint'(pre_at), 200);
        issue("R10", 0, 0, 0, 0, 0, 0, 1, 100, 300, 250, 0);
        cmp("pre_write", longint'(pre_at), 312);

        // R2: start held and inputs changed while busy are ignored
        clear_q();
        put(0, 10, 0, 1, 5);
        cur_req = "R2";
        is_read = 1; rank = '0; bank = 3'd1; row = 14'd5; self_slot = '0;
        mode = 2'd1; acc = 8'd1; cmd_t = 32'd20; ready_t = 32'd30; prev_t = 32'd0;
        start = 1'b1;
        @(negedge clk);
        row = 14'd6; mode = 2'd2; cmd_t = 32'd900;
        repeat (3) @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        cmp("close_expected", longint'(close_f), 0);
        cmp("pre_latched", longint'(pre_at), 24);

        // R11: results hold after the done pulse
        cur_req = "R11";
        repeat (4) @(negedge clk);
        cmp("close_hold", longint'(close_f), 0);
        cmp("pre_hold", longint'(pre_at), 24);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule